// File: doc/BRIEF.md
# Prioritized Level Interrupt Controller

This block gathers a set of interrupt request lines into a pending register and raises one request toward a processor core. Each source is fixed at build time as level-type or edge-type and is tied to a priority level from 1 up to the number of levels. A source set to level 0 is never signalled. A source counts as qualifying when its pending bit and its enable bit are both set. For each level, the controller forms the set of sources tied to that level. It then walks from the highest level down and stops at the first level that holds a qualifying source. It considers only levels strictly above the processor's current masking level.

Software reaches the block through a small register port with combinational read data. Address 0 is the pending register, which is write-one-to-clear for edge-type bits. Address 1 is the enable mask. The request and the chosen level are computed combinationally from the registered pending and enable state and the current-level input. Input lines are sampled into the pending register on the clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: When a line at index below NUM_IRQ is high at a rising clock edge, its pending bit (register address 0, bit = line index) reads 1 after that edge. For an edge-type source this holds when the line was low at the edge before.
- R2: A level-type pending bit reads 0 after an edge at which its line is low. Writing 1 to it at address 0 has no effect.
- R3: An edge-type pending bit is set on a low-to-high transition of its line. It stays set after the line returns low, and is cleared only by writing 1 to its bit at address 0. A rising transition in the same cycle as that clear leaves the bit set. A line held high does not set the bit again after it has been cleared.
- R4: The enable mask is written and read at address 1. Only sources whose pending and enable bits are both 1 can produce a request.
- R5: With the default map (sources 0 and 1 at level 1, 2 and 3 at level 2, 4 and 5 at level 3; sources 1, 3 and 5 edge-type), irq_level is the highest level that holds a qualifying source.
- R6: Only levels strictly greater than cur_level are considered. A qualifying source at or below cur_level produces no request.
- R7: When no level qualifies, irq_level is 0 and irq_req is 0. irq_req is 1 exactly when irq_level is nonzero.
- R8: Lines at index NUM_IRQ and above are ignored. Register bits at those positions read 0, and writes to them are ignored.
- R9: After reset, the pending and enable registers read 0, irq_level is 0 and irq_req is 0.
- R10: irq_level and irq_req follow a change of cur_level in the same cycle, with no clock edge. A change of pending or enable state shows on the outputs right after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | LINE_W | Interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 pending, 1 enable |
| reg_wdata | input | LINE_W | Register write data |
| reg_rdata | output | LINE_W | Register read data (combinational) |
| cur_level | input | LVL_W | Current processor masking level |
| irq_level | output | LVL_W | Highest qualifying level, 0 if none |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach is a clear of an edge-type bit that lands in the same cycle as a fresh rising transition on its line. The clear write and the line change have to be lined up on one clock edge. The bench does this by driving the line high and raising the write strobe together before a single clock step. The other hard case is a line held high after its pending bit has been cleared, which checks that the bit is not set again. The bench clears the bit while the line stays high, then steps the clock again.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   localparam int MAX_LINES = 32;

   typedef enum logic [1:0] {
      ADDR_PEND = 2'd0,
      ADDR_EN   = 2'd1
   } reg_addr_e;

endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
   parameter int                   NUM_IRQ   = 6,
   parameter logic [NUM_IRQ-1:0]   EDGE_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] line_i,
   input  logic [NUM_IRQ-1:0] clr_i,
   output logic [NUM_IRQ-1:0] pend_o
);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      if (EDGE_MASK[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q    <= 1'b0;
               pend_o[i] <= 1'b0;
            end else begin
               prev_q    <= line_i[i];
               pend_o[i] <= (line_i[i] & ~prev_q) | (pend_o[i] & ~clr_i[i]);
            end
         end

         assert_edge_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
         assert_edge_set_R1 : assert property (@(posedge clk) disable iff (!rst_n)
            $rose(line_i[i]) |=> pend_o[i]);
      end else begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_o[i] <= 1'b0;
            else        pend_o[i] <= line_i[i];
         end

         assert_level_clear_R2 : assert property (@(posedge clk) disable iff (!rst_n)
            !line_i[i] |=> !pend_o[i]);
         assert_level_set_R1 : assert property (@(posedge clk) disable iff (!rst_n)
            line_i[i] |=> pend_o[i]);
      end
   end

endmodule

// File: rtl/prio_irq_resolve.sv
module prio_irq_resolve #(
   parameter int                          NUM_IRQ = 6,
   parameter int                          NUM_LVL = 3,
   parameter int                          LVL_W   = 2,
   parameter logic [NUM_IRQ*LVL_W-1:0]    PRIO    = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] qual_i,
   input  logic [LVL_W-1:0]   cur_i,
   output logic [LVL_W-1:0]   level_o,
   output logic               req_o
);

   logic [NUM_IRQ-1:0] lvl_mask [1:NUM_LVL];

   for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
         assign lvl_mask[l][i] = (PRIO[i*LVL_W +: LVL_W] == LVL_W'(l));
      end
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chk
      if (int'(PRIO[i*LVL_W +: LVL_W]) > NUM_LVL) begin : g_bad
         $error("prio_irq_resolve: source priority exceeds NUM_LVL");
      end
   end

   always_comb begin
      logic hit;
      hit     = 1'b0;
      level_o = '0;
      for (int l = NUM_LVL; l >= 1; l--) begin
         if (!hit && (LVL_W'(l) > cur_i) && |(lvl_mask[l] & qual_i)) begin
            hit     = 1'b1;
            level_o = LVL_W'(l);
         end
      end
      req_o = hit;
   end

   assert_above_cur_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (level_o > cur_i));
   assert_idle_zero_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_o |-> (level_o == '0));
   assert_needs_qual_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (qual_i != '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int                        LINE_W    = 8,
   parameter int                        NUM_IRQ   = 6,
   parameter int                        NUM_LVL   = 3,
   parameter int                        LVL_W     = $clog2(NUM_LVL + 1),
   parameter logic [NUM_IRQ-1:0]        EDGE_MASK = 6'b101010,
   parameter logic [NUM_IRQ*LVL_W-1:0]  PRIO      = 12'hFA5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] irq_lines,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [LINE_W-1:0] reg_wdata,
   output logic [LINE_W-1:0] reg_rdata,
   input  logic [LVL_W-1:0]  cur_level,
   output logic [LVL_W-1:0]  irq_level,
   output logic              irq_req
);

   if (LINE_W > MAX_LINES || NUM_IRQ > LINE_W || NUM_IRQ < 1) begin : g_bad_width
      $error("prio_irq_ctrl: need 1 <= NUM_IRQ <= LINE_W <= 32");
   end
   if (NUM_LVL < 1 || LVL_W != $clog2(NUM_LVL + 1)) begin : g_bad_lvl
      $error("prio_irq_ctrl: LVL_W must equal clog2(NUM_LVL+1)");
   end

   logic [NUM_IRQ-1:0] en_q;
   logic [NUM_IRQ-1:0] pend;
   logic [NUM_IRQ-1:0] clr;
   logic [NUM_IRQ-1:0] qual;
   logic               wr_pend;
   logic               wr_en;

   assign wr_pend = reg_we && (reg_addr == ADDR_PEND);
   assign wr_en   = reg_we && (reg_addr == ADDR_EN);
   assign clr     = wr_pend ? reg_wdata[NUM_IRQ-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (wr_en) en_q <= reg_wdata[NUM_IRQ-1:0];
   end

   prio_irq_pend #(
      .NUM_IRQ   (NUM_IRQ),
      .EDGE_MASK (EDGE_MASK)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (irq_lines[NUM_IRQ-1:0]),
      .clr_i  (clr),
      .pend_o (pend)
   );

   assign qual = pend & en_q;

   prio_irq_resolve #(
      .NUM_IRQ (NUM_IRQ),
      .NUM_LVL (NUM_LVL),
      .LVL_W   (LVL_W),
      .PRIO    (PRIO)
   ) u_resolve (
      .clk     (clk),
      .rst_n   (rst_n),
      .qual_i  (qual),
      .cur_i   (cur_level),
      .level_o (irq_level),
      .req_o   (irq_req)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_PEND: reg_rdata[NUM_IRQ-1:0] = pend;
         ADDR_EN:   reg_rdata[NUM_IRQ-1:0] = en_q;
         default:   reg_rdata = '0;
      endcase
   end

   if (NUM_IRQ < LINE_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^{irq_lines[LINE_W-1:NUM_IRQ], reg_wdata[LINE_W-1:NUM_IRQ]};

      assert_ignore_hi_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         reg_rdata[LINE_W-1:NUM_IRQ] == '0);
   end

endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int LINE_W = 8;
   localparam int LVL_W  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LINE_W-1:0] irq_lines = '0;
   logic              reg_we = 1'b0;
   logic [1:0]        reg_addr = 2'd0;
   logic [LINE_W-1:0] reg_wdata = '0;
   logic [LINE_W-1:0] reg_rdata;
   logic [LVL_W-1:0]  cur_level = '0;
   logic [LVL_W-1:0]  irq_level;
   logic              irq_req;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_irq_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_lines (irq_lines),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .cur_level (cur_level),
      .irq_level (irq_level),
      .irq_req   (irq_req)
   );

   // {lines[7:0], enable[7:0], cur_level[1:0], expected level[1:0]}
   localparam logic [19:0] VEC [14] = '{
      {8'h01, 8'h3F, 2'd0, 2'd1},
      {8'h05, 8'h3F, 2'd0, 2'd2},
      {8'h15, 8'h3F, 2'd0, 2'd3},
      {8'h15, 8'h0F, 2'd0, 2'd2},
      {8'h15, 8'h3F, 2'd2, 2'd3},
      {8'h15, 8'h3F, 2'd3, 2'd0},
      {8'h05, 8'h3F, 2'd2, 2'd0},
      {8'h0A, 8'h3F, 2'd1, 2'd2},
      {8'h20, 8'h3F, 2'd0, 2'd3},
      {8'h00, 8'h3F, 2'd0, 2'd0},
      {8'h3F, 8'h00, 2'd0, 2'd0},
      {8'hC0, 8'hFF, 2'd0, 2'd0},
      {8'h03, 8'h3F, 2'd1, 2'd0},
      {8'h22, 8'h22, 2'd2, 2'd3}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_out(input string tag, input int lvl);
      check({tag, " level"}, int'(irq_level), lvl);
      check({tag, " req"}, int'(irq_req), int'(lvl != 0));
   endtask

   task automatic rd(input logic [1:0] a, input string tag, input int exp);
      reg_addr = a;
      #1;
      check(tag, int'(reg_rdata), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      // R9 reset state
      check_out("R9 reset", 0);
      rd(2'd0, "R9 pending", 0);
      rd(2'd1, "R9 enable", 0);

      // vector table: R5 R6 R7 R4 R8
      foreach (VEC[k]) begin
         irq_lines = '0;
         step();
         wr(2'd0, 8'hFF);
         wr(2'd1, VEC[k][11:4]);
         cur_level = VEC[k][3:2];
         irq_lines = VEC[k][19:12];
         step();
         check_out($sformatf("R5 vector %0d", k), int'(VEC[k][1:0]));
      end
      irq_lines = '0; cur_level = '0;
      step();
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'h3F);
      rd(2'd1, "R4 enable readback", 'h3F);

      // R3 pulse stays pending, cleared by W1C
      irq_lines = 8'h02; step();
      irq_lines = 8'h00; step();
      rd(2'd0, "R3 held after release", 'h02);
      check_out("R3 held after release", 1);
      wr(2'd0, 8'h02);
      rd(2'd0, "R3 cleared", 0);
      check_out("R3 cleared", 0);

      // R1/R2 level source
      irq_lines = 8'h01; step();
      rd(2'd0, "R1 set", 'h01);
      wr(2'd0, 8'h01);
      rd(2'd0, "R2 W1C ignored on level", 'h01);
      irq_lines = 8'h00; step();
      rd(2'd0, "R2 cleared on release", 0);
      check_out("R2 cleared on release", 0);

      // R3 line held high after clear
      irq_lines = 8'h08; step();
      check_out("R3 edge set", 2);
      wr(2'd0, 8'h08);
      step();
      rd(2'd0, "R3 no reset while held", 0);
      check_out("R3 no reset while held", 0);
      irq_lines = 8'h00; step();

      // R3 rising edge together with clear
      irq_lines = 8'h20;
      wr(2'd0, 8'h20);
      rd(2'd0, "R3 set wins over clear", 'h20);
      check_out("R3 set wins over clear", 3);
      irq_lines = 8'h00;
      wr(2'd0, 8'h20);

      // R10 combinational level tracking
      irq_lines = 8'h15; step();
      cur_level = 2'd3; #1;
      check_out("R10 cur 3", 0);
      cur_level = 2'd1; #1;
      check_out("R10 cur 1", 3);
      cur_level = 2'd0;
      wr(2'd1, 8'h03);
      check_out("R10 enable change", 1);

      // R8 upper lines and bits ignored
      irq_lines = 8'h00; step();
      wr(2'd1, 8'hFF);
      rd(2'd1, "R8 enable upper bits", 'h3F);
      irq_lines = 8'hC0; step();
      rd(2'd0, "R8 upper lines", 0);
      check_out("R8 upper lines", 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule